// File: doc/BRIEF.md
# Time-Division Column Driver Sequencer

This block is the digital sequencer for a display column driver in which one fast voltage-selector converter is shared by 24 column channels. Each line period it takes a snapshot of 24 pixel codes of 10 bits and feeds them to the converter one at a time, channel 1 first. Each code is split into a 6-bit coarse field and a 4-bit fine field, and each field is presented as a one-hot select word. The coarse word picks a pair of adjacent levels. The fine word picks one of 16 interpolation taps between them.

The converted values are parked on 12 holding capacitors, so the line is handled as two halves. First, channels 1 to 12 are sampled into holders 1 to 12, one per slot. All 12 buffers then drive the lower group of loads. Next, channels 13 to 24 are sampled into the same holders, and the buffers are switched to the upper group of loads. Each buffer therefore has a pair of output switches. The enables for these two switches are never on together, and there is always a quiet cycle between sampling and driving.

The slot length and the drive length are set in clock cycles and are captured when the line starts. A line-start pulse that arrives in the middle of a sequence aborts the sequence and restarts it.

Top module: `tdcd_sequencer`

## Requirements
- R1: While reset is held and after its release (with no line start), every select, sample enable and drive enable is low, and `line_done` is low.
- R2: A `line_start` pulse captures all 24 codes, `slot_len` and `drive_len`. Changes on `pix_codes`, `slot_len` or `drive_len` after that edge have no effect until the next `line_start`.
- R3: The cycle after the line-start edge is quiet. Then the slots follow in channel order 1 to 24. During a slot for channel c (0-based, c = 12·g + j), `samp_en` is exactly bit j. Channel c occupies bits [10·c+9 : 10·c] of `pix_codes`.
- R4: During every active slot cycle, `coarse_sel` has exactly one bit set, at position code[9:4]. `fine_sel` has exactly one bit set, at position code[3:0].
- R5: Each slot has `slot_len` active cycles followed by one gap cycle. In the gap cycle, `coarse_sel`, `fine_sel` and `samp_en` are all zero. Outside active slot cycles the selects are always zero.
- R6: After the last gap of the first half, `drv_lo_en` is all ones for `drive_len` cycles, followed by one all-low cycle. After the second half, `drv_hi_en` does the same.
- R7: No cycle has both a sample enable and a drive enable high. `drv_lo_en` and `drv_hi_en` are never both non-zero. A cycle with a sample enable is never directly followed by a cycle with a drive enable, and the reverse holds too.
- R8: `line_done` rises in the cycle after the last drive gap of the second half. It stays high, with every enable low, until the next `line_start`.
- R9: A `line_start` in mid-sequence makes the next cycle fully quiet. The sequence then restarts from channel 1 with the newly captured codes and lengths.
- R10: A captured `slot_len` or `drive_len` of zero behaves as a length of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-line pulse; captures codes and lengths |
| pix_codes | input | 240 | 24 packed pixel codes, channel 1 in the low bits |
| slot_len | input | 12 | Active cycles per conversion slot |
| drive_len | input | 12 | Active cycles per drive phase |
| coarse_sel | output | 64 | One-hot coarse level-pair select |
| fine_sel | output | 16 | One-hot interpolation tap select |
| samp_en | output | 12 | One-hot holder sample-switch enables |
| drv_lo_en | output | 12 | Buffer-to-lower-channel switch enables |
| drv_hi_en | output | 12 | Buffer-to-upper-channel switch enables |
| line_done | output | 1 | Sequence for the current line finished |

## Verification
Every output is decoded from registered state. A `line_start` seen at one rising edge therefore produces the quiet arm cycle right after that edge, and the first sample enable appears one edge later. From then on, each slot, gap and drive cycle advances by exactly one edge. The reference model in the bench rebuilds the full per-cycle output schedule whenever a line starts. It removes one entry per edge and compares that entry against the outputs at the falling edge that follows. Because of this, any result that arrives one cycle early or one cycle late is reported at the cycle where it goes wrong.

// File: rtl/tdcd_pkg.sv
package tdcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SAMP,
        ST_DRV,
        ST_DONE
    } seq_st_e;
endpackage

// File: rtl/tdcd_onehot.sv
module tdcd_onehot #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 1 << IN_W
) (
    input  logic             en,
    input  logic [IN_W-1:0]  val,
    output logic [OUT_W-1:0] oh
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign oh[i] = en && (val == IN_W'(i));
    end
endmodule

// File: rtl/tdcd_code_bank.sv
module tdcd_code_bank #(
    parameter int N_CH   = 24,
    parameter int CODE_W = 10,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [N_CH*CODE_W-1:0]   codes_in,
    input  logic [CH_W-1:0]          rd_ch,
    output logic [CODE_W-1:0]        rd_code
);
    logic [CODE_W-1:0] code_d [N_CH];
    logic [CODE_W-1:0] code_q [N_CH];

    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            code_d[i] = capture ? codes_in[i*CODE_W +: CODE_W] : code_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CH; i++) begin
            if (!rst_n) code_q[i] <= '0;
            else        code_q[i] <= code_d[i];
        end
    end

    assign rd_code = code_q[rd_ch];
endmodule

// File: rtl/tdcd_ctrl.sv
module tdcd_ctrl
    import tdcd_pkg::*;
#(
    parameter int HALF  = 12,
    parameter int CNT_W = 12,
    localparam int IDX_W = $clog2(HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [CNT_W-1:0] slot_len,
    input  logic [CNT_W-1:0] drive_len,
    output logic             samp_act,
    output logic             drv_act,
    output logic             grp,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    typedef struct packed {
        seq_st_e          st;
        logic             grp;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] slot_l;
        logic [CNT_W-1:0] drv_l;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [CNT_W-1:0] slot_eff, drv_eff;

    assign slot_eff = (s_q.slot_l == '0) ? CNT_W'(1) : s_q.slot_l;
    assign drv_eff  = (s_q.drv_l  == '0) ? CNT_W'(1) : s_q.drv_l;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_ARM: begin
                s_d.st  = ST_SAMP;
                s_d.grp = 1'b0;
                s_d.idx = '0;
                s_d.cnt = '0;
            end
            ST_SAMP: begin
                if (s_q.cnt == slot_eff) begin
                    s_d.cnt = '0;
                    if (s_q.idx == IDX_W'(HALF-1)) begin
                        s_d.st  = ST_DRV;
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_DRV: begin
                if (s_q.cnt == drv_eff) begin
                    s_d.cnt = '0;
                    if (!s_q.grp) begin
                        s_d.grp = 1'b1;
                        s_d.st  = ST_SAMP;
                    end else begin
                        s_d.st  = ST_DONE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
        if (line_start) begin
            s_d.st     = ST_ARM;
            s_d.grp    = 1'b0;
            s_d.idx    = '0;
            s_d.cnt    = '0;
            s_d.slot_l = slot_len;
            s_d.drv_l  = drive_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, grp: 1'b0, idx: '0, cnt: '0, slot_l: '0, drv_l: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign samp_act = (s_q.st == ST_SAMP) && (s_q.cnt != slot_eff);
    assign drv_act  = (s_q.st == ST_DRV)  && (s_q.cnt != drv_eff);
    assign grp      = s_q.grp;
    assign idx      = s_q.idx;
    assign done     = (s_q.st == ST_DONE);

    // R3: the holder index stays inside the half-group
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx < IDX_W'(HALF));
endmodule

// File: rtl/tdcd_sequencer.sv
module tdcd_sequencer #(
    parameter int N_CH   = 24,
    parameter int CODE_W = 10,
    parameter int FINE_W = 4,
    parameter int CNT_W  = 12,
    localparam int HALF     = N_CH / 2,
    localparam int COARSE_W = CODE_W - FINE_W,
    localparam int CH_W     = $clog2(N_CH),
    localparam int IDX_W    = $clog2(HALF)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_start,
    input  logic [N_CH*CODE_W-1:0]      pix_codes,
    input  logic [CNT_W-1:0]            slot_len,
    input  logic [CNT_W-1:0]            drive_len,
    output logic [(1<<COARSE_W)-1:0]    coarse_sel,
    output logic [(1<<FINE_W)-1:0]      fine_sel,
    output logic [HALF-1:0]             samp_en,
    output logic [HALF-1:0]             drv_lo_en,
    output logic [HALF-1:0]             drv_hi_en,
    output logic                        line_done
);
    logic             samp_act, drv_act, grp;
    logic [IDX_W-1:0] idx;
    logic [CH_W-1:0]  ch;
    logic [CODE_W-1:0] code;

    tdcd_ctrl #(.HALF(HALF), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .slot_len(slot_len), .drive_len(drive_len),
        .samp_act(samp_act), .drv_act(drv_act), .grp(grp), .idx(idx),
        .done(line_done)
    );

    assign ch = CH_W'(idx) + (grp ? CH_W'(HALF) : CH_W'(0));

    tdcd_code_bank #(.N_CH(N_CH), .CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .capture(line_start),
        .codes_in(pix_codes), .rd_ch(ch), .rd_code(code)
    );

    tdcd_onehot #(.IN_W(COARSE_W)) u_coarse (
        .en(samp_act), .val(code[CODE_W-1:FINE_W]), .oh(coarse_sel)
    );

    tdcd_onehot #(.IN_W(FINE_W)) u_fine (
        .en(samp_act), .val(code[FINE_W-1:0]), .oh(fine_sel)
    );

    tdcd_onehot #(.IN_W(IDX_W), .OUT_W(HALF)) u_holder (
        .en(samp_act), .val(idx), .oh(samp_en)
    );

    assign drv_lo_en = {HALF{drv_act && !grp}};
    assign drv_hi_en = {HALF{drv_act &&  grp}};

    // R3
    p_samp_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(samp_en));
    // R4
    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|samp_en) |-> ($countones(coarse_sel) == 1 && $countones(fine_sel) == 1));
    // R5
    p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|samp_en) |-> (coarse_sel == '0 && fine_sel == '0));
    // R7
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !((|samp_en) && (|(drv_lo_en | drv_hi_en))));
    p_pair_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !((|drv_lo_en) && (|drv_hi_en)));
    p_dead_s2d_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|samp_en) |=> !(|(drv_lo_en | drv_hi_en)));
    p_dead_d2s_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(drv_lo_en | drv_hi_en)) |=> !(|samp_en));
    // R8
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (samp_en == '0 && drv_lo_en == '0 && drv_hi_en == '0));
    // R9
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (samp_en == '0 && drv_lo_en == '0 && drv_hi_en == '0 && !line_done));
endmodule

// File: tb/tdcd_sequencer_bench.sv
module tdcd_sequencer_bench;
    localparam int NCH = 24;
    localparam int HF  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic [NCH*10-1:0] pix_codes = '0;
    logic [11:0] slot_len = '0;
    logic [11:0] drive_len = '0;
    logic [63:0] coarse_sel;
    logic [15:0] fine_sel;
    logic [HF-1:0] samp_en, drv_lo_en, drv_hi_en;
    logic line_done;

    always #10 clk = ~clk;

    tdcd_sequencer u_tdcd_sequencer (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_codes(pix_codes),
        .slot_len(slot_len), .drive_len(drive_len), .coarse_sel(coarse_sel),
        .fine_sel(fine_sel), .samp_en(samp_en), .drv_lo_en(drv_lo_en),
        .drv_hi_en(drv_hi_en), .line_done(line_done)
    );

    typedef struct {
        logic [HF-1:0] s, lo, hi;
        logic [63:0]   c;
        logic [15:0]   f;
        logic          d;
        int            tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   pix_arr [NCH];
    int   lat [NCH];
    bit   armed = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 0;

    function automatic exp_t quiet(input int tag);
        exp_t e;
        e.s = '0; e.lo = '0; e.hi = '0; e.c = '0; e.f = '0; e.d = 1'b0; e.tag = tag;
        return e;
    endfunction

    function automatic void pack_pix();
        for (int i = 0; i < NCH; i++) pix_codes[i*10 +: 10] = 10'(pix_arr[i]);
    endfunction

    // Build the full expected schedule of a line from the requirements (R3..R6, R10)
    function automatic void build_line(input int sl, input int dl);
        int l_eff = (sl == 0) ? 1 : sl;
        int d_eff = (dl == 0) ? 1 : dl;
        q.delete();
        for (int g = 0; g < 2; g++) begin
            for (int j = 0; j < HF; j++) begin
                int code = lat[g*HF + j];
                for (int k = 0; k < l_eff; k++) begin
                    exp_t e = quiet(3);
                    e.s = HF'(1) << j;
                    e.c = 64'(1) << (code >> 4);
                    e.f = 16'(1) << (code & 15);
                    q.push_back(e);
                end
                q.push_back(quiet(5));
            end
            for (int k = 0; k < d_eff; k++) begin
                exp_t e = quiet((dl == 0) ? 10 : 6);
                if (g == 0) e.lo = '1; else e.hi = '1;
                q.push_back(e);
            end
            q.push_back(quiet(6));
        end
    endfunction

    task automatic fail_line(input int tag, input string what, input logic [63:0] act, input logic [63:0] exp_v);
        n_fail++;
        $display("FAIL R%0d %s actual=%h expected=%h at %0t", tag, what, act, exp_v, $time);
    endtask

    task automatic compare();
        int tag_sel = (cur.tag == 3) ? 4 : cur.tag;
        n_run++;
        if (samp_en !== cur.s)      fail_line(cur.tag, "samp_en", 64'(samp_en), 64'(cur.s));
        if (coarse_sel !== cur.c)   fail_line(tag_sel, "coarse_sel", coarse_sel, cur.c);
        if (fine_sel !== cur.f)     fail_line(tag_sel, "fine_sel", 64'(fine_sel), 64'(cur.f));
        if (drv_lo_en !== cur.lo)   fail_line(cur.tag, "drv_lo_en", 64'(drv_lo_en), 64'(cur.lo));
        if (drv_hi_en !== cur.hi)   fail_line(cur.tag, "drv_hi_en", 64'(drv_hi_en), 64'(cur.hi));
        if (line_done !== cur.d)    fail_line(8, "line_done", 64'(line_done), 64'(cur.d));
        // R7: separate structural check of switch exclusivity on the outputs
        n_run++;
        if (((|samp_en) && (|(drv_lo_en | drv_hi_en))) || ((|drv_lo_en) && (|drv_hi_en)))
            fail_line(7, "switch overlap", {samp_en, drv_lo_en, drv_hi_en}, 64'(0));
    endtask

    // One clock: compare at the falling edge, then drive inputs and advance the model
    task automatic cyc(input bit ls);
        compare();
        line_start = ls;
        if (!rst_n) begin
            cur = quiet(1);
        end else if (ls) begin
            for (int i = 0; i < NCH; i++) lat[i] = pix_arr[i];   // R2 capture
            build_line(int'(slot_len), int'(drive_len));
            cur = quiet(9);
            armed = 1;
        end else if (q.size() > 0) begin
            cur = q.pop_front();
        end else if (armed) begin
            cur = quiet(8);
            cur.d = 1'b1;
        end else begin
            cur = quiet(1);
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0);
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        if (!finished) begin
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cur = quiet(1);
        for (int i = 0; i < NCH; i++) pix_arr[i] = 0;
        pack_pix();
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++) cyc(1'b0);
        rst_n = 1'b1;
        run(4);

        // Line A: L=3 D=5, mid-line changes to codes and lengths (R2)
        for (int i = 0; i < NCH; i++) pix_arr[i] = (i * 37 + 5) % 1024;
        pack_pix();
        slot_len = 12'd3; drive_len = 12'd5;
        cyc(1'b1);
        run(20);
        for (int i = 0; i < NCH; i++) pix_arr[i] = 1023 - i;   // R2: must be ignored
        pack_pix();
        slot_len = 12'd7; drive_len = 12'd2;
        run(100);

        // Line B: lengths of zero (R10), boundary codes 0 and 1023 (R4)
        for (int i = 0; i < NCH; i++) pix_arr[i] = (i % 2 == 0) ? 0 : 1023;
        pack_pix();
        slot_len = 12'd0; drive_len = 12'd0;
        cyc(1'b1);
        run(60);

        // Line C: abort during sampling (R9)
        for (int i = 0; i < NCH; i++) pix_arr[i] = (i * 101 + 17) % 1024;
        pack_pix();
        slot_len = 12'd2; drive_len = 12'd4;
        cyc(1'b1);
        run(15);
        for (int i = 0; i < NCH; i++) pix_arr[i] = (i * 29 + 400) % 1024;
        pack_pix();
        cyc(1'b1);
        run(95);

        // Line D: abort during the first drive phase (R9)
        slot_len = 12'd1; drive_len = 12'd10;
        cyc(1'b1);
        run(30);
        for (int i = 0; i < NCH; i++) pix_arr[i] = 1000 - i * 40;
        pack_pix();
        cyc(1'b1);
        run(80);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule